// File: doc/BRIEF.md
# Banked GPIO Port with Per-Bit Inversion

This block is one general-purpose I/O port that sits in a logical device of a configuration register space. Software reaches it through three byte registers at consecutive addresses starting at a base chosen by parameter. The first register sets each pin's direction, the second carries pin data, and the third holds a per-pin inversion mask. The port turns these registers into pin output values and output enables, and it returns the synchronized pin levels when software reads the data register.

The inversion mask acts on both paths. On a read, the data register returns the synchronized pin level XOR the mask. On a write, the data written is XORed with the mask before it is stored as the level to drive. Three inputs from global configuration control the drive. The port enable input gates all output enables. The driver mode input selects push-pull or open-drain for the whole port. An optional two-bit pin routing field releases the pins to the port only when it holds the GPIO code. A pin count parameter gives narrow variants whose unused upper register bits read as zero.

Top module: `gpio_bank_port`

## Requirements
- R1: After reset every direction bit is 1 (all pins are inputs), the stored drive level and the inversion mask are 0, and no output enable is asserted.
- R2: The direction register is at BASE_ADDR, the data register at BASE_ADDR+1 and the inversion register at BASE_ADDR+2. A write to any other address changes nothing, and a read of any other address returns 0.
- R3: A direction bit of 1 makes its pin an input with its output enable low. A direction bit of 0 makes the pin an output.
- R4: A read of the data register returns, for each pin, the synchronized pin level XOR that pin's inversion bit.
- R5: A write to the data register stores, for each pin, the written bit XOR the inversion bit in force at that write. The stored value is the level the pin drives.
- R6: With pushPull at 1 and the port live, every output pin has its enable asserted and pinOut equals the stored level.
- R7: With pushPull at 0 (open-drain), pinOut is 0 on every pin. An output pin is enabled only where its stored level is 0, so a stored 1 leaves the pin at high impedance.
- R8: While portEnable is 0, every output enable is deasserted.
- R9: When ROUTE_GATED is 1, output enables are asserted only while routeSel equals 2. When ROUTE_GATED is 0, routeSel has no effect.
- R10: With PIN_COUNT below 8, register bits at and above PIN_COUNT read as 0, and writing them has no effect.
- R11: A change of a pin's level appears in the data readback after exactly two rising clock edges.
- R12: Register reads are combinational on the current register state. A register written in a cycle returns its old value in that cycle and the new value after the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 8 | Register address for reads and writes |
| regWrEn | input | 1 | Write strobe for the addressed register |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data of the addressed register |
| portEnable | input | 1 | Global port enable bit |
| pushPull | input | 1 | Global driver mode: 1 push-pull, 0 open-drain |
| routeSel | input | 2 | Pin routing field; value 2 gives the pins to the port |
| pinIn | input | PIN_COUNT | Asynchronous pin levels |
| pinOut | output | PIN_COUNT | Pin drive values |
| pinOe | output | PIN_COUNT | Pin output enables |

## Verification
Two functions can land in the same cycle. One is a write to the inversion register while that same register, or the data register, is being read back. The other is a pin level change that is still moving through the synchronizer while the inversion mask changes. The bench sets the address to the register under write and samples the read data just before and just after the write edge. It expects the old value before the edge and the new value after it. It also changes pin levels at chosen edges and counts two edges before it expects the readback to change. A behavioural model, updated on every edge, judges both the readback and the pin drive on every cycle.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int REG_W = 8;
  localparam logic [1:0] ROUTE_GPIO = 2'd2;

  typedef struct packed {
    logic wrDir;
    logic wrData;
    logic wrInv;
    logic rdDir;
    logic rdData;
    logic rdInv;
  } portStrobe_t;
endpackage

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter logic [REG_W-1:0] BASE_ADDR = 8'hE0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [REG_W-1:0] regAddr,
  input  logic             regWrEn,
  output portStrobe_t      strobe
);
  localparam logic [REG_W-1:0] ADDR_DIR  = BASE_ADDR;
  localparam logic [REG_W-1:0] ADDR_DATA = BASE_ADDR + 8'd1;
  localparam logic [REG_W-1:0] ADDR_INV  = BASE_ADDR + 8'd2;

  logic hitDir, hitData, hitInv;

  always_comb begin
    hitDir  = (regAddr == ADDR_DIR);
    hitData = (regAddr == ADDR_DATA);
    hitInv  = (regAddr == ADDR_INV);
    strobe.rdDir  = hitDir;
    strobe.rdData = hitData;
    strobe.rdInv  = hitInv;
    strobe.wrDir  = regWrEn & hitDir;
    strobe.wrData = regWrEn & hitData;
    strobe.wrInv  = regWrEn & hitInv;
  end

  // R2: at most one register is targeted
  a_r2_single_target: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrDir, strobe.wrData, strobe.wrInv}));

  // R2: no write strobe without a write request
  a_r2_no_stray_write: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn |-> ({strobe.wrDir, strobe.wrData, strobe.wrInv} == 3'b000));
endmodule

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] rawIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stageA;
  logic [WIDTH-1:0] stageB;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stageA[i] <= 1'b0;
        stageB[i] <= 1'b0;
      end else begin
        stageA[i] <= rawIn[i];
        stageB[i] <= stageA[i];
      end
    end
  end

  assign syncOut = stageB;

  logic [1:0] warmCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) warmCnt <= 2'd0;
    else if (warmCnt != 2'd2) warmCnt <= warmCnt + 2'd1;
  end

  // R11: output is the input delayed by exactly two edges
  a_r11_two_stage: assert property (@(posedge clk) disable iff (!rstN)
    (warmCnt == 2'd2) |-> (syncOut == $past(rawIn, 2)));
endmodule

// File: rtl/gpio_port_datapath.sv
module gpio_port_datapath
  import gpio_port_pkg::*;
#(
  parameter int PIN_COUNT   = 8,
  parameter bit ROUTE_GATED = 1'b1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  portStrobe_t          strobe,
  input  logic [REG_W-1:0]     wrData,
  input  logic                 portEnable,
  input  logic                 pushPull,
  input  logic [1:0]           routeSel,
  input  logic [PIN_COUNT-1:0] syncIn,
  output logic [PIN_COUNT-1:0] pinOut,
  output logic [PIN_COUNT-1:0] pinOe,
  output logic [REG_W-1:0]     rdData
);
  logic [PIN_COUNT-1:0] dirReg;
  logic [PIN_COUNT-1:0] latchReg;
  logic [PIN_COUNT-1:0] invReg;
  logic [PIN_COUNT-1:0] wrBits;
  logic                 portLive;

  assign wrBits = wrData[PIN_COUNT-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirReg   <= '1;
      latchReg <= '0;
      invReg   <= '0;
    end else begin
      if (strobe.wrDir)  dirReg   <= wrBits;
      if (strobe.wrData) latchReg <= wrBits ^ invReg;
      if (strobe.wrInv)  invReg   <= wrBits;
    end
  end

  if (ROUTE_GATED) begin : g_routed
    assign portLive = portEnable & (routeSel == ROUTE_GPIO);
  end else begin : g_direct
    logic [1:0] routeUnused;
    assign routeUnused = routeSel;
    assign portLive = portEnable;
  end

  for (genvar i = 0; i < PIN_COUNT; i++) begin : g_drive
    assign pinOe[i]  = portLive & ~dirReg[i] & (pushPull | ~latchReg[i]);
    assign pinOut[i] = pushPull & latchReg[i];
  end

  always_comb begin
    rdData = '0;
    if (strobe.rdDir)  rdData[PIN_COUNT-1:0] = dirReg;
    if (strobe.rdData) rdData[PIN_COUNT-1:0] = syncIn ^ invReg;
    if (strobe.rdInv)  rdData[PIN_COUNT-1:0] = invReg;
  end

  // R8: disabled port never drives
  a_r8_disabled_no_drive: assert property (@(posedge clk) disable iff (!rstN)
    !portEnable |-> (pinOe == '0));

  // R7: open-drain never drives a high level
  a_r7_od_never_high: assert property (@(posedge clk) disable iff (!rstN)
    !pushPull |-> ((pinOut == '0) && ((pinOe & latchReg) == '0)));

  // R3: input pins never enabled
  a_r3_inputs_float: assert property (@(posedge clk) disable iff (!rstN)
    (pinOe & dirReg) == '0);

  // R5: a data write stores the value through the inversion mask
  a_r5_write_lands: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrData |=> (latchReg == $past(wrBits ^ invReg)));

  // R12: inversion mask only changes on its own write
  a_r12_inv_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrInv |=> $stable(invReg));

  if (ROUTE_GATED) begin : g_route_chk
    // R9: pins not routed to the port are never driven
    a_r9_route_gate: assert property (@(posedge clk) disable iff (!rstN)
      (routeSel != ROUTE_GPIO) |-> (pinOe == '0));
  end

  if (PIN_COUNT < REG_W) begin : g_narrow_chk
    // R10: unused upper bits read as zero
    a_r10_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
      rdData[REG_W-1:PIN_COUNT] == '0);
  end
endmodule

// File: rtl/gpio_bank_port.sv
module gpio_bank_port
  import gpio_port_pkg::*;
#(
  parameter int               PIN_COUNT   = 8,
  parameter logic [REG_W-1:0] BASE_ADDR   = 8'hE0,
  parameter bit               ROUTE_GATED = 1'b1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [REG_W-1:0]     regAddr,
  input  logic                 regWrEn,
  input  logic [REG_W-1:0]     regWrData,
  output logic [REG_W-1:0]     regRdData,
  input  logic                 portEnable,
  input  logic                 pushPull,
  input  logic [1:0]           routeSel,
  input  logic [PIN_COUNT-1:0] pinIn,
  output logic [PIN_COUNT-1:0] pinOut,
  output logic [PIN_COUNT-1:0] pinOe
);
  portStrobe_t          strobe;
  logic [PIN_COUNT-1:0] syncLevel;

  gpio_port_ctrl #(.BASE_ADDR(BASE_ADDR)) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .strobe  (strobe)
  );

  gpio_port_sync #(.WIDTH(PIN_COUNT)) i_sync (
    .clk     (clk),
    .rstN    (rstN),
    .rawIn   (pinIn),
    .syncOut (syncLevel)
  );

  gpio_port_datapath #(.PIN_COUNT(PIN_COUNT), .ROUTE_GATED(ROUTE_GATED)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .wrData     (regWrData),
    .portEnable (portEnable),
    .pushPull   (pushPull),
    .routeSel   (routeSel),
    .syncIn     (syncLevel),
    .pinOut     (pinOut),
    .pinOe      (pinOe),
    .rdData     (regRdData)
  );
endmodule

// File: tb/test_gpio_bank_port.sv
module test_gpio_bank_port;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] regAddr = 8'h00;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic       portEnable = 1'b0;
  logic       pushPull = 1'b1;
  logic [1:0] routeSel = 2'd2;
  logic [7:0] pinIn = 8'h00;

  logic [7:0] wRd, nRd;
  logic [7:0] wOut, wOe;
  logic [4:0] nOut, nOe;

  int nChecks = 0;
  int nFail = 0;

  always #5 clk = ~clk;

  gpio_bank_port i_gpio_bank_port (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(wRd), .portEnable(portEnable),
    .pushPull(pushPull), .routeSel(routeSel), .pinIn(pinIn),
    .pinOut(wOut), .pinOe(wOe)
  );

  gpio_bank_port #(.PIN_COUNT(5), .BASE_ADDR(8'hE4), .ROUTE_GATED(1'b0)) i_gpio_bank_port_narrow (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(nRd), .portEnable(portEnable),
    .pushPull(pushPull), .routeSel(routeSel), .pinIn(pinIn[4:0]),
    .pinOut(nOut), .pinOe(nOe)
  );

  // behavioural reference: index 0 wide port, index 1 narrow port
  logic [7:0] mDir[2], mLat[2], mInv[2], mS1[2], mS2[2];
  logic [7:0] mMask[2] = '{8'hFF, 8'h1F};
  logic [7:0] mBase[2] = '{8'hE0, 8'hE4};
  bit         mGated[2] = '{1'b1, 1'b0};
  bit         started = 1'b0;

  always @(posedge clk) begin
    for (int k = 0; k < 2; k++) begin
      if (!rstN) begin
        mDir[k] <= mMask[k]; mLat[k] <= 8'h00; mInv[k] <= 8'h00;
        mS1[k] <= 8'h00; mS2[k] <= 8'h00;
      end else begin
        if (regWrEn && regAddr == mBase[k])        mDir[k] <= regWrData & mMask[k];
        if (regWrEn && regAddr == mBase[k] + 8'd1) mLat[k] <= (regWrData ^ mInv[k]) & mMask[k];
        if (regWrEn && regAddr == mBase[k] + 8'd2) mInv[k] <= regWrData & mMask[k];
        mS1[k] <= pinIn & mMask[k];
        mS2[k] <= mS1[k];
      end
    end
    started <= 1'b1;
  end

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] expRd(int k);
    if (regAddr == mBase[k])        return mDir[k];
    if (regAddr == mBase[k] + 8'd1) return mS2[k] ^ mInv[k];
    if (regAddr == mBase[k] + 8'd2) return mInv[k];
    return 8'h00;
  endfunction

  function automatic logic [7:0] expOe(int k);
    bit live = portEnable && (!mGated[k] || routeSel == 2'd2);
    if (!live) return 8'h00;
    return ~mDir[k] & (pushPull ? mMask[k] : ~mLat[k]) & mMask[k];
  endfunction

  // compare against the model on every cycle
  always @(negedge clk) begin
    if (started) begin
      check("R4 R2 R12 wide read", wRd, expRd(0));
      check("R10 R2 narrow read", nRd, expRd(1));
      check("R3 R6 R7 R8 R9 wide enable", wOe, expOe(0));
      check("R3 R7 R8 R10 narrow enable", {3'b000, nOe}, expOe(1));
      check("R5 R6 R7 wide drive", wOut, pushPull ? mLat[0] : 8'h00);
      check("R5 R10 narrow drive", {3'b000, nOut}, pushPull ? mLat[1] : 8'h00);
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wrReg(logic [7:0] a, logic [7:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    tick(1);
    regWrEn = 1'b0;
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  initial begin
    #2_000_000;
    nChecks++; nFail++;
    $display("FAIL watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    regAddr = 8'hE0;
    @(negedge clk);
    check("R1 dir reset", wRd, 8'hFF);
    check("R1 no enables", wOe, 8'h00);
    check("R2 narrow ignores other base", nRd, 8'h00);
    regAddr = 8'hE4;
    @(negedge clk);
    check("R1 narrow dir reset", nRd, 8'h1F);

    tick(1);
    wrReg(8'hE3, 8'h00);
    regAddr = 8'hE3;
    @(negedge clk);
    check("R2 unmapped reads zero", wRd, 8'h00);
    regAddr = 8'hE0;
    @(negedge clk);
    check("R2 unmapped write ignored", wRd, 8'hFF);

    tick(1);
    portEnable = 1'b1;
    wrReg(8'hE0, 8'hF0);
    wrReg(8'hE1, 8'h5A);
    @(negedge clk);
    check("R3 only outputs enabled", wOe, 8'h0F);
    check("R6 push-pull drive", wOut, 8'h5A);

    tick(1);
    wrReg(8'hE2, 8'hFF);
    wrReg(8'hE1, 8'h0F);
    @(negedge clk);
    check("R5 write through inversion", wOut, 8'hF0);

    tick(1);
    pinIn = 8'h3C;
    regAddr = 8'hE1;
    tick(2);
    @(negedge clk);
    check("R4 inverted readback", wRd, 8'hC3);

    tick(1);
    pinIn = 8'h00;
    @(negedge clk);
    check("R11 no change before edges", wRd, 8'hC3);
    tick(1);
    @(negedge clk);
    check("R11 no change after one edge", wRd, 8'hC3);
    tick(1);
    @(negedge clk);
    check("R11 change after two edges", wRd, 8'hFF);

    tick(1);
    regAddr = 8'hE2; regWrData = 8'h00; regWrEn = 1'b1;
    @(negedge clk);
    check("R12 old value in write cycle", wRd, 8'hFF);
    tick(1);
    regWrEn = 1'b0;
    @(negedge clk);
    check("R12 new value after edge", wRd, 8'h00);

    tick(1);
    wrReg(8'hE1, 8'h05);
    pushPull = 1'b0;
    @(negedge clk);
    check("R7 open-drain enables", wOe, 8'h0A);
    check("R7 open-drain drive", wOut, 8'h00);

    tick(1);
    pushPull = 1'b1;
    portEnable = 1'b0;
    @(negedge clk);
    check("R8 disabled enables", wOe, 8'h00);

    tick(1);
    portEnable = 1'b1;
    routeSel = 2'd1;
    @(negedge clk);
    check("R9 unrouted enables", wOe, 8'h00);
    tick(1);
    routeSel = 2'd2;
    @(negedge clk);
    check("R9 routed enables", wOe, 8'h0F);

    tick(1);
    wrReg(8'hE4, 8'h00);
    regAddr = 8'hE4;
    @(negedge clk);
    check("R10 narrow dir write", nRd, 8'h00);
    tick(1);
    wrReg(8'hE6, 8'hFF);
    regAddr = 8'hE6;
    @(negedge clk);
    check("R10 narrow inversion upper bits", nRd, 8'h1F);
    tick(1);
    wrReg(8'hE5, 8'hE0);
    @(negedge clk);
    check("R10 narrow drive", {3'b000, nOut}, 8'h1F);
    check("R10 narrow enables", {3'b000, nOe}, 8'h1F);
    tick(1);
    routeSel = 2'd0;
    @(negedge clk);
    check("R9 ungated variant ignores route", {3'b000, nOe}, 8'h1F);
    tick(1);
    wrReg(8'hE4, 8'hFF);
    regAddr = 8'hE4;
    @(negedge clk);
    check("R10 narrow dir upper bits", nRd, 8'h1F);

    tick(2);
    finishRun();
  end
endmodule